// File: doc/BRIEF.md
# Parallel ADC Result Read Controller

This block sits on the host side of a parallel bus that connects it to a 12-bit, 8-channel successive-approximation converter. The converter raises `busy` while it converts. When `busy` falls, a new result is waiting. The controller then lowers the active-low chip select and read strobe together and captures the data lines on the clock edge where the strobe is released. It presents the reassembled sample on a valid/ready output.

A static mode pin selects between two transfer widths. In word mode (`word_mode` = 1), one strobe returns all 12 bits. In byte mode (`word_mode` = 0), two strobes on the lower eight lines return the result. The controller drives `hben` to choose the half: low byte first, then high byte. The high byte carries the four result MSBs, the 3-bit channel number and a bit that must read zero. The strobe-low width and the recovery gap after each strobe are parameters given in clock cycles.

The sequencer has four states:
- IDLE waits for a pending result, `busy` low and an empty output.
- STB_A is the first strobe: the whole word, or the low byte.
- REC is the recovery gap.
- STB_B is the high-byte strobe.

The transitions are:
- IDLE→STB_A on start.
- STB_A→REC and STB_B→REC when the strobe time is over.
- REC→STB_B when a high byte is still owed.
- REC→IDLE otherwise.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted, `cs_n` and `rd_n` are high, `hben` is low and `res_valid` is low.
- R2: A read sequence starts only after a high-to-low transition of `busy` has been seen since the previous sequence started. The strobe never falls while `busy` is high. Without such a transition, no strobe occurs.
- R3: In word mode, one strobe per result is issued. `res_data` equals `db_in[11:0]` as sampled in the last strobe-low cycle, `res_chan` is 0, `res_err` is 0 and `hben` stays low.
- R4: In byte mode, two strobes per result are issued. The first has `hben` = 0 (low byte) and the second has `hben` = 1 (high byte).
- R5: In byte mode, `res_data` = {high[3:0], low[7:0]} and `res_chan` = high[6:4]. Here low and high are `db_in[7:0]` captured in the last cycle of the first and second strobe. `db_in[11:8]` is ignored.
- R6: In byte mode, `res_err` equals bit 7 of the high byte. It is 1 when that bit, which should be zero, reads as one.
- R7: `cs_n` and `rd_n` always carry the same level.
- R8: Each strobe holds `rd_n` low for exactly `STB_CYC` clock cycles.
- R9: After every strobe, `rd_n` stays high for at least `GAP_CYC` cycles. Between the low-byte and high-byte strobes the gap is exactly `GAP_CYC`.
- R10: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data`, `res_chan` and `res_err` hold steady. No strobe is issued while a result is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode | input | 1 | 1 = one 12-bit read, 0 = two byte reads; change only while idle |
| busy | input | 1 | Converter busy, high during conversion |
| db_in | input | 12 | Data lines from the converter |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| hben | output | 1 | High-byte select in byte mode, held low in word mode |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 12 | Reassembled sample |
| res_chan | output | 3 | Channel number (0 in word mode) |
| res_err | output | 1 | High byte framing bit was set |

## Verification
The bench drives the upper data lines with inverted junk during byte reads. A design that took the nibble from the wrong lines, or swapped the byte order, returns a wrong sample. It holds `busy` high for varying lengths and watches each strobe edge. A strobe launched before `busy` fell, or one launched twice for a single conversion, shows up as an early or extra edge. It ends a conversion while a result is still unaccepted. A design that ignored back-pressure would strobe again or overwrite the held result. Strobe widths and the inter-byte gap are measured edge to edge, so an off-by-one counter is visible.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STB_A,
        ST_REC,
        ST_STB_B
    } rd_state_e;

endpackage

// File: rtl/adc_rd_busy_track.sv
module adc_rd_busy_track (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic take,
    output logic pending
);

    logic busy_q;
    logic fell;

    assign fell = busy_q & ~busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            pending <= 1'b0;
        end else begin
            busy_q <= busy;
            if (fell)
                pending <= 1'b1;
            else if (take)
                pending <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_rd_fsm.sv
module adc_rd_fsm
    import adc_rd_pkg::*;
#(
    parameter int STB_CYC = 3,
    parameter int GAP_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_mode,
    input  logic busy,
    input  logic pending,
    input  logic out_full,
    output logic take,
    output logic cap_word,
    output logic cap_lo,
    output logic cap_hi,
    output logic cs_n,
    output logic rd_n,
    output logic hben
);

    localparam int MAX_CYC = (STB_CYC > GAP_CYC) ? STB_CYC : GAP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    rd_state_e        state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             mode_q;
    logic             hi_q;
    logic             stb_end;
    logic             gap_end;

    assign stb_end = (cnt == CNT_W'(STB_CYC - 1));
    assign gap_end = (cnt == CNT_W'(GAP_CYC - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            mode_q <= 1'b1;
            hi_q   <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
            if (take)
                mode_q <= word_mode;
            if (cap_lo)
                hi_q <= 1'b1;
            else if (cap_hi)
                hi_q <= 1'b0;
        end
    end

    // transitions
    always_comb begin
        nxt      = state;
        take     = 1'b0;
        cap_word = 1'b0;
        cap_lo   = 1'b0;
        cap_hi   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (pending && !busy && !out_full) begin
                    take = 1'b1;
                    nxt  = ST_STB_A;
                end
            end
            ST_STB_A: begin
                if (stb_end) begin
                    cap_word = mode_q;
                    cap_lo   = ~mode_q;
                    nxt      = ST_REC;
                end
            end
            ST_REC: begin
                if (gap_end)
                    nxt = hi_q ? ST_STB_B : ST_IDLE;
            end
            ST_STB_B: begin
                if (stb_end) begin
                    cap_hi = 1'b1;
                    nxt    = ST_REC;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cs_n = 1'b1;
        rd_n = 1'b1;
        if (state == ST_STB_A || state == ST_STB_B) begin
            cs_n = 1'b0;
            rd_n = 1'b0;
        end
        hben = hi_q;
    end

endmodule

// File: rtl/adc_rd_assemble.sv
module adc_rd_assemble #(
    parameter int DW = 12,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] db_in,
    input  logic          cap_word,
    input  logic          cap_lo,
    input  logic          cap_hi,
    input  logic          res_ready,
    output logic          res_valid,
    output logic [DW-1:0] res_data,
    output logic [CW-1:0] res_chan,
    output logic          res_err
);

    localparam int BYTE_W   = 8;
    localparam int HI_W     = DW - BYTE_W;
    localparam int FLAG_BIT = HI_W + CW;

    logic [BYTE_W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q      <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
            res_chan  <= '0;
            res_err   <= 1'b0;
        end else begin
            if (res_valid && res_ready)
                res_valid <= 1'b0;
            if (cap_lo)
                lo_q <= db_in[BYTE_W-1:0];
            if (cap_word) begin
                res_valid <= 1'b1;
                res_data  <= db_in;
                res_chan  <= '0;
                res_err   <= 1'b0;
            end else if (cap_hi) begin
                res_valid <= 1'b1;
                res_data  <= {db_in[HI_W-1:0], lo_q};
                res_chan  <= db_in[HI_W +: CW];
                res_err   <= db_in[FLAG_BIT];
            end
        end
    end

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
    parameter int DW      = 12,
    parameter int CW      = 3,
    parameter int STB_CYC = 3,
    parameter int GAP_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_mode,
    input  logic          busy,
    input  logic [DW-1:0] db_in,
    output logic          cs_n,
    output logic          rd_n,
    output logic          hben,
    output logic          res_valid,
    input  logic          res_ready,
    output logic [DW-1:0] res_data,
    output logic [CW-1:0] res_chan,
    output logic          res_err
);

    logic pending;
    logic take;
    logic cap_word;
    logic cap_lo;
    logic cap_hi;

    adc_rd_busy_track u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .take    (take),
        .pending (pending)
    );

    adc_rd_fsm #(
        .STB_CYC (STB_CYC),
        .GAP_CYC (GAP_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_mode (word_mode),
        .busy      (busy),
        .pending   (pending),
        .out_full  (res_valid),
        .take      (take),
        .cap_word  (cap_word),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .hben      (hben)
    );

    adc_rd_assemble #(
        .DW (DW),
        .CW (CW)
    ) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .db_in     (db_in),
        .cap_word  (cap_word),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .res_ready (res_ready),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_chan  (res_chan),
        .res_err   (res_err)
    );

endmodule

// File: rtl/adc_rd_check.sv
module adc_rd_check #(
    parameter int DW      = 12,
    parameter int CW      = 3,
    parameter int STB_CYC = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          word_mode,
    input logic          busy,
    input logic          cs_n,
    input logic          rd_n,
    input logic          hben,
    input logic          res_valid,
    input logic          res_ready,
    input logic [DW-1:0] res_data,
    input logic [CW-1:0] res_chan,
    input logic          res_err
);

    logic [15:0] lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lo_run <= '0;
        else if (rd_n)
            lo_run <= '0;
        else
            lo_run <= lo_run + 1'b1;
    end

    assert_cs_rd_tied_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n == rd_n);

    assert_no_strobe_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> !busy);

    assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> (lo_run == 16'(STB_CYC)));

    assert_word_no_hben_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_mode |-> !hben);

    assert_err_byte_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err) |-> !word_mode);

    assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=>
            (res_valid && $stable(res_data) && $stable(res_chan) && $stable(res_err)));

    assert_no_read_while_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> rd_n);

endmodule

bind adc_rd_ctrl adc_rd_check #(
    .DW      (DW),
    .CW      (CW),
    .STB_CYC (STB_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_mode (word_mode),
    .busy      (busy),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .hben      (hben),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .res_chan  (res_chan),
    .res_err   (res_err)
);

// File: tb/adc_rd_ctrl_test.sv
module adc_rd_ctrl_test;

    localparam int STB = 3;
    localparam int GAP = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        word_mode;
    logic        busy;
    logic [11:0] db_in;
    logic        cs_n, rd_n, hben;
    logic        res_valid, res_ready;
    logic [11:0] res_data;
    logic [2:0]  res_chan;
    logic        res_err;

    logic [11:0] cv_data;
    logic [2:0]  cv_chan;
    logic        cv_b7;

    int total = 0, bad = 0;
    int mon_total = 0, mon_bad = 0;
    int n_strobe = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    adc_rd_ctrl #(.STB_CYC(STB), .GAP_CYC(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .busy(busy),
        .db_in(db_in), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .res_chan(res_chan), .res_err(res_err)
    );

    // converter bus model; upper lines carry junk in byte mode
    always_comb begin
        if (!cs_n && !rd_n) begin
            if (word_mode)
                db_in = cv_data;
            else if (hben)
                db_in = {~cv_data[11:8], cv_b7, cv_chan, cv_data[11:8]};
            else
                db_in = {~cv_data[11:8], cv_data[7:0]};
        end else begin
            db_in = 12'h5A5;
        end
    end

    // strobe monitor
    bit prev_rd = 1'b1, seen = 1'b0, hb_prev = 1'b0, hb_cur = 1'b0;
    int lo_run = 0, hi_run = 0;

    task automatic mchk(input bit ok, input string req, input int act, input int exp);
        mon_total++;
        if (!ok) begin
            mon_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_rd && !rd_n) begin
                n_strobe++;
                hb_prev = hb_cur;
                hb_cur  = hben;
                mchk(!busy, "R2 strobe while busy", int'(busy), 0);
                mchk(cs_n == rd_n, "R7 cs_n tied to rd_n", int'(cs_n), int'(rd_n));
                if (seen) mchk(hi_run >= GAP, "R9 recovery gap", hi_run, GAP);
                if (seen && hben) mchk(hi_run == GAP, "R9 inter-byte gap", hi_run, GAP);
                seen   = 1'b1;
                lo_run = 1;
            end else if (!prev_rd && rd_n) begin
                mchk(lo_run == STB, "R8 strobe width", lo_run, STB);
                hi_run = 1;
            end else if (!rd_n) begin
                lo_run++;
            end else begin
                hi_run++;
            end
            prev_rd = rd_n;
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic [11:0] exp_data(input bit m, input [11:0] d);
        logic [7:0] lo, hi;
        lo = d[7:0];
        hi = {1'b0, 3'b000, d[11:8]};
        return m ? d : {hi[3:0], lo};
    endfunction

    function automatic [2:0] exp_chan(input bit m, input [2:0] c);
        return m ? 3'd0 : c;
    endfunction

    task automatic convert(input [11:0] d, input [2:0] c, input bit b7, input int blen);
        cv_data = d; cv_chan = c; cv_b7 = b7;
        busy = 1'b1;
        tick(blen);
        busy = 1'b0;
    endtask

    task automatic expect_result(input [11:0] d, input [2:0] c, input bit b7, input int base);
        int w = 0;
        @(negedge clk);
        while (!res_valid && w < 2000) begin
            @(negedge clk);
            w++;
        end
        chk(res_valid, "R2 result arrives", int'(res_valid), 1);
        chk(res_data == exp_data(word_mode, d), word_mode ? "R3 word data" : "R5 byte data",
            int'(res_data), int'(exp_data(word_mode, d)));
        chk(res_chan == exp_chan(word_mode, c), word_mode ? "R3 word chan" : "R5 byte chan",
            int'(res_chan), int'(exp_chan(word_mode, c)));
        chk(res_err == (!word_mode && b7), word_mode ? "R3 word err" : "R6 framing err",
            int'(res_err), int'(!word_mode && b7));
        chk((n_strobe - base) == (word_mode ? 1 : 2), word_mode ? "R3 one strobe" : "R4 two strobes",
            n_strobe - base, word_mode ? 1 : 2);
        if (word_mode)
            chk(hb_cur == 1'b0, "R3 hben low", int'(hb_cur), 0);
        else
            chk(hb_prev == 1'b0 && hb_cur == 1'b1, "R4 byte order",
                int'({hb_prev, hb_cur}), 1);
    endtask

    task automatic accept(input int hold);
        logic [11:0] d0;
        logic [2:0]  c0;
        logic        e0;
        int          s0;
        d0 = res_data; c0 = res_chan; e0 = res_err; s0 = n_strobe;
        tick(1);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(res_valid && res_data == d0 && res_chan == c0 && res_err == e0,
                "R10 hold result", int'(res_data), int'(d0));
            tick(1);
        end
        chk(n_strobe == s0, "R10 no strobe while full", n_strobe, s0);
        res_ready = 1'b1;
        tick(1);
        res_ready = 1'b0;
        @(negedge clk);
        chk(!res_valid, "R10 valid drops after accept", int'(res_valid), 0);
        tick(GAP + 3);
    endtask

    task automatic one(input bit m, input [11:0] d, input [2:0] c, input bit b7,
                       input int blen, input int hold);
        int base;
        word_mode = m;
        tick(1);
        base = n_strobe;
        convert(d, c, b7, blen);
        expect_result(d, c, b7, base);
        accept(hold);
    endtask

    initial begin
        int base;
        void'($urandom(32'h1A2B3C4D));
        rst_n = 1'b0; word_mode = 1'b1; busy = 1'b0; res_ready = 1'b0;
        cv_data = '0; cv_chan = '0; cv_b7 = 1'b0;
        tick(5);
        @(negedge clk);
        chk(cs_n && rd_n, "R1 strobes high in reset", int'({cs_n, rd_n}), 3);
        chk(!hben, "R1 hben low in reset", int'(hben), 0);
        chk(!res_valid, "R1 valid low in reset", int'(res_valid), 0);
        rst_n = 1'b1;
        tick(20);
        chk(n_strobe == 0, "R2 no read without busy fall", n_strobe, 0);

        // directed corners
        one(1'b1, 12'hABC, 3'd0, 1'b0, 3, 0);
        one(1'b0, 12'h123, 3'd5, 1'b0, 3, 2);
        one(1'b0, 12'h9E7, 3'd2, 1'b1, 4, 0);
        one(1'b0, 12'hFFF, 3'd7, 1'b0, 1, 1);
        one(1'b0, 12'h000, 3'd0, 1'b0, 30, 0);
        one(1'b1, 12'h000, 3'd0, 1'b0, 1, 0);
        one(1'b1, 12'hFFF, 3'd0, 1'b1, 2, 3);

        // back-pressure: second conversion ends while first result waits
        word_mode = 1'b0;
        tick(1);
        base = n_strobe;
        convert(12'h4C1, 3'd6, 1'b0, 3);
        expect_result(12'h4C1, 3'd6, 1'b0, base);
        base = n_strobe;
        convert(12'h3B2, 3'd1, 1'b0, 2);
        tick(15);
        @(negedge clk);
        chk(n_strobe == base, "R10 no strobe while result waits", n_strobe, base);
        chk(res_data == 12'h4C1, "R10 first result kept", int'(res_data), 12'h4C1);
        res_ready = 1'b1;
        tick(1);
        res_ready = 1'b0;
        expect_result(12'h3B2, 3'd1, 1'b0, base);
        accept(0);

        // random
        for (int k = 0; k < 150; k++) begin
            one(1'($urandom), 12'($urandom), 3'($urandom), ($urandom % 8) == 0,
                1 + int'($urandom % 8), int'($urandom % 5));
        end

        tick(20);
        chk(!res_valid && rd_n, "R2 quiet after last result", int'(rd_n), 1);
        $display("  test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
        $finish;
    end

endmodule